// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block produces the word address for a synchronous burst memory of 32K words. On a clock edge where an access begins, it captures a 15-bit external address. On later edges it steps the two least significant address bits through a four-beat burst while the upper thirteen bits stay fixed. A static order input selects the sequence. When it is high, the sequence is interleaved: each beat is the start bits XOR the beat number. When it is low, the sequence is linear: each beat is the start bits plus the beat number, modulo four.

There are two active-low start strobes. The host strobe only counts when the first select is active. If the first select is inactive, a host strobe is disregarded entirely. The controller strobe counts whatever the selects are. It either loads the address, when all three selects are valid, or deselects the block. With no start strobe, the active-low step input advances the burst, and leaving it high suspends the burst. The outputs come straight from registers, so every decision becomes visible one cycle after the edge that sampled it. All inputs are sampled on the rising edge of the clock, and the reset is synchronous.

Top module: `burst_addr_seq`

## Requirements
- R1: A host strobe (`host_start_n`=0) with `sel1_n`=0, `sel2`=1 and `sel3_n`=0 loads `base_addr` into `word_addr` and sets `burst_on`=1; both are visible in the next cycle.
- R2: During a burst, bits [14:2] of `word_addr` never change, and advancing past the fourth beat wraps back to the start address with no carry into bit 2.
- R3: With `order_xor`=1, beat n (0..3) presents low bits equal to the start bits XOR n; starting at 01 this gives 01, 00, 11, 10.
- R4: With `order_xor`=0, beat n presents low bits equal to (start + n) mod 4; starting at 10 this gives 10, 11, 00, 01.
- R5: A host strobe with `sel1_n`=1 is disregarded, and the edge is decoded as though `host_start_n` were 1. With `ctrl_start_n`=1 and `step_n`=1, both outputs therefore hold; with `step_n`=0 in an active burst, the burst advances.
- R6: A counted start strobe with invalid selects (`sel1_n`=1, `sel2`=0 or `sel3_n`=1) clears `burst_on` and leaves `word_addr` unchanged.
- R7: A controller strobe (`ctrl_start_n`=0) with valid selects loads the address and starts a burst exactly as R1 does.
- R8: With no counted start strobe, `step_n`=0 advances one beat only while `burst_on`=1; `step_n`=1, or an inactive burst, holds `word_addr`.
- R9: A synchronous reset (`rst_n`=0) drives `burst_on` to 0 and `word_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_start_n | input | 1 | Host start strobe, active low, needs sel1_n low to count |
| ctrl_start_n | input | 1 | Controller start strobe, active low |
| step_n | input | 1 | Advance the burst when low, suspend when high |
| sel1_n | input | 1 | First select, active low |
| sel2 | input | 1 | Second select, active high, sampled only with a start strobe |
| sel3_n | input | 1 | Third select, active low, sampled only with a start strobe |
| order_xor | input | 1 | Burst order: 1 interleaved, 0 linear |
| base_addr | input | 15 | External word address |
| word_addr | output | 15 | Current word address |
| burst_on | output | 1 | A selected burst is active |

## Verification
The stored start bits, beat count and upper address feed `word_addr` with no extra register. A corrupted beat count or start value therefore shows up as a wrong low address in the cycle right after the edge that caused it. A wrong select decode shows at once, either as `burst_on` set or cleared on the wrong edge, or as a load that should not have happened. A missing wrap or a carry into bit 2 becomes visible on the fifth beat of a burst, which the scoreboard checks against the captured start address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_STEP  = 2'd1,
    CMD_LOAD  = 2'd2,
    CMD_DESEL = 2'd3
  } seq_cmd_e;
endpackage

// File: rtl/burst_start_qual.sv
module burst_start_qual
  import burst_seq_pkg::*;
(
  input  logic     host_start_n,
  input  logic     ctrl_start_n,
  input  logic     step_n,
  input  logic     sel1_n,
  input  logic     sel2,
  input  logic     sel3_n,
  input  logic     active,
  output seq_cmd_e cmd
);
  logic host_live;
  logic ctrl_live;
  logic selected;

  // The host strobe only counts while the first select is active.
  assign host_live = !host_start_n && !sel1_n;
  assign ctrl_live = !ctrl_start_n;
  assign selected  = !sel1_n && sel2 && !sel3_n;

  always_comb begin
    if (host_live || ctrl_live) begin
      cmd = selected ? CMD_LOAD : CMD_DESEL;
    end else if (active && !step_n) begin
      cmd = CMD_STEP;
    end else begin
      cmd = CMD_HOLD;
    end
  end
endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_bits,
  input  logic [BEAT_W-1:0] beat,
  input  logic              order_xor,
  output logic [BEAT_W-1:0] low_bits
);
  logic [BEAT_W-1:0] xor_bits;
  logic [BEAT_W-1:0] lin_bits;

  genvar gi;
  generate
    for (gi = 0; gi < BEAT_W; gi++) begin : g_xor
      assign xor_bits[gi] = start_bits[gi] ^ beat[gi];
    end
  endgenerate

  // The sum is truncated to BEAT_W bits, so the linear order wraps.
  assign lin_bits = start_bits + beat;
  assign low_bits = order_xor ? xor_bits : lin_bits;
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  seq_cmd_e                 cmd,
  input  logic [ADDR_W-1:0]        base_addr,
  output logic [ADDR_W-BEAT_W-1:0] upper_q,
  output logic [BEAT_W-1:0]        start_q,
  output logic [BEAT_W-1:0]        beat_q,
  output logic                     active_q
);
  localparam int UP_W = ADDR_W - BEAT_W;
  localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q  <= '0;
      start_q  <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_LOAD: begin
          upper_q  <= base_addr[ADDR_W-1:BEAT_W];
          start_q  <= base_addr[BEAT_W-1:0];
          beat_q   <= '0;
          active_q <= 1'b1;
        end
        CMD_STEP:  beat_q   <= beat_q + BEAT_ONE;
        CMD_DESEL: active_q <= 1'b0;
        default: ;
      endcase
    end
  end

  logic [UP_W-1:0] unused_w;
  assign unused_w = upper_q;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_start_n,
  input  logic              ctrl_start_n,
  input  logic              step_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] word_addr,
  output logic              burst_on
);
  localparam int UP_W = ADDR_W - BEAT_W;

  seq_cmd_e          cmd;
  logic [UP_W-1:0]   upper_q;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_bits;
  logic              active_q;

  burst_start_qual u_qual (
    .host_start_n (host_start_n),
    .ctrl_start_n (ctrl_start_n),
    .step_n       (step_n),
    .sel1_n       (sel1_n),
    .sel2         (sel2),
    .sel3_n       (sel3_n),
    .active       (active_q),
    .cmd          (cmd)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .base_addr (base_addr),
    .upper_q   (upper_q),
    .start_q   (start_q),
    .beat_q    (beat_q),
    .active_q  (active_q)
  );

  burst_order_gen #(.BEAT_W(BEAT_W)) u_order (
    .start_bits (start_q),
    .beat       (beat_q),
    .order_xor  (order_xor),
    .low_bits   (low_bits)
  );

  assign word_addr = {upper_q, low_bits};
  assign burst_on  = active_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 15,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_start_n,
  input logic              ctrl_start_n,
  input logic              step_n,
  input logic              sel1_n,
  input logic              sel2,
  input logic              sel3_n,
  input logic              order_xor,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] word_addr,
  input logic              burst_on
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  AST_HOST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_start_n && !sel1_n && sel2 && !sel3_n)
    |=> (burst_on && word_addr == $past(base_addr))); // R1

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_start_n && !sel1_n && sel2 && !sel3_n)
    |=> (burst_on && word_addr == $past(base_addr))); // R7

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_start_n && ctrl_start_n)
    |=> (word_addr[ADDR_W-1:BEAT_W] == $past(word_addr[ADDR_W-1:BEAT_W]))); // R2

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_on && host_start_n && ctrl_start_n && !step_n && !order_xor)
    |=> (order_xor || word_addr[BEAT_W-1:0] == $past(word_addr[BEAT_W-1:0]) + ONE)); // R4

  AST_MASKED_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_start_n && sel1_n && ctrl_start_n && step_n)
    |=> ($stable(word_addr) && $stable(burst_on))); // R5

  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_start_n && (sel1_n || !sel2 || sel3_n))
    |=> (!burst_on && $stable(word_addr))); // R6

  AST_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_start_n || sel1_n) && ctrl_start_n && step_n)
    |=> $stable(word_addr)); // R8
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_start_n (host_start_n),
  .ctrl_start_n (ctrl_start_n),
  .step_n       (step_n),
  .sel1_n       (sel1_n),
  .sel2         (sel2),
  .sel3_n       (sel3_n),
  .order_xor    (order_xor),
  .base_addr    (base_addr),
  .word_addr    (word_addr),
  .burst_on     (burst_on)
);

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_start_n = 1'b1;
  logic        ctrl_start_n = 1'b1;
  logic        step_n = 1'b1;
  logic        sel1_n = 1'b1;
  logic        sel2 = 1'b0;
  logic        sel3_n = 1'b1;
  logic        order_xor = 1'b0;
  logic [14:0] base_addr = '0;
  logic [14:0] word_addr;
  logic        burst_on;

  always #2.5 clk = ~clk;

  burst_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .host_start_n(host_start_n), .ctrl_start_n(ctrl_start_n),
    .step_n(step_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .order_xor(order_xor), .base_addr(base_addr), .word_addr(word_addr), .burst_on(burst_on)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [14:0] q_addr[$];
  logic        q_act[$];
  string       q_tag[$];

  // Reference state, kept from the requirements.
  logic [12:0] m_up = '0;
  logic [1:0]  m_start = '0;
  logic [1:0]  m_beat = '0;
  logic        m_act = 1'b0;

  function automatic logic [14:0] model_addr(input logic il);
    logic [1:0] lo;
    lo = il ? (m_start ^ m_beat) : (m_start + m_beat);
    return {m_up, lo};
  endfunction

  task automatic drive(input logic hs, input logic cs, input logic st, input logic s1,
                       input logic s2, input logic s3, input logic [14:0] a,
                       input logic il, input string tag);
    logic host_ok;
    logic strobe;
    @(negedge clk);
    host_start_n = hs; ctrl_start_n = cs; step_n = st;
    sel1_n = s1; sel2 = s2; sel3_n = s3; base_addr = a; order_xor = il;
    host_ok = !hs && !s1;
    strobe  = host_ok || !cs;
    if (strobe) begin
      if (!s1 && s2 && !s3) begin
        m_up = a[14:2]; m_start = a[1:0]; m_beat = 2'd0; m_act = 1'b1;
      end else begin
        m_act = 1'b0;
      end
    end else if (m_act && !st) begin
      m_beat = m_beat + 2'd1;
    end
    q_addr.push_back(model_addr(il));
    q_act.push_back(m_act);
    q_tag.push_back(tag);
  endtask

  // Monitor: compare one expected item per clock, 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (q_addr.size() > 0) begin
      logic [14:0] ea;
      logic        eb;
      string       t;
      ea = q_addr.pop_front();
      eb = q_act.pop_front();
      t  = q_tag.pop_front();
      total++;
      if (word_addr !== ea || burst_on !== eb) begin
        bad++;
        $display("FAIL %s: addr=%h on=%b expected addr=%h on=%b", t, word_addr, burst_on, ea, eb);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: done=0 expected done=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset clears the flag and the address
    @(negedge clk);
    q_addr.push_back(15'h0); q_act.push_back(1'b0); q_tag.push_back("R9 reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R1 + R3: host start at ..01, interleaved
    drive(0, 1, 1, 0, 1, 0, 15'h1235, 1, "R1 host load");
    drive(1, 1, 0, 0, 1, 0, 15'h0000, 1, "R3 beat1");
    drive(1, 1, 0, 0, 1, 0, 15'h0000, 1, "R3 beat2");
    drive(1, 1, 0, 0, 1, 0, 15'h0000, 1, "R3 beat3");
    drive(1, 1, 0, 0, 1, 0, 15'h0000, 1, "R2 wrap interleaved");
    // R8: suspend
    drive(1, 1, 1, 1, 0, 1, 15'h7fff, 1, "R8 suspend");
    drive(1, 1, 1, 0, 1, 0, 15'h7fff, 1, "R8 suspend again");
    // R7 + R4: controller start at ..10, linear, top of the space
    drive(1, 0, 1, 0, 1, 0, 15'h7ffe, 0, "R7 ctrl load");
    drive(1, 1, 0, 0, 1, 0, 15'h0000, 0, "R4 beat1");
    drive(1, 1, 0, 0, 1, 0, 15'h0000, 0, "R4 beat2");
    drive(1, 1, 0, 0, 1, 0, 15'h0000, 0, "R4 beat3");
    drive(1, 1, 0, 0, 1, 0, 15'h0000, 0, "R2 wrap linear no carry");
    // R5: masked host strobe holds, then advances with step low
    drive(0, 1, 1, 1, 1, 0, 15'h0123, 0, "R5 masked hold");
    drive(0, 1, 0, 1, 1, 0, 15'h0123, 0, "R5 masked advance");
    // R6: deselects
    drive(1, 0, 1, 1, 1, 0, 15'h0456, 0, "R6 ctrl with sel1 high");
    drive(1, 1, 0, 0, 1, 0, 15'h0000, 0, "R8 step while inactive");
    drive(0, 1, 1, 0, 1, 0, 15'h2a29, 0, "R1 host reload");
    drive(0, 1, 1, 0, 0, 0, 15'h1111, 0, "R6 host with sel2 low");
    drive(1, 0, 1, 0, 1, 0, 15'h4443, 1, "R7 ctrl load interleaved");
    drive(1, 0, 1, 0, 1, 1, 15'h3333, 1, "R6 ctrl with sel3 high");
    drive(1, 0, 1, 0, 1, 0, 15'h0003, 0, "R7 ctrl load linear 11");
    drive(1, 1, 0, 0, 1, 0, 15'h0000, 0, "R4 wrap 11 to 00");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule